// File: doc/BRIEF.md
# Next-PC Branch Unit

This block works out where a 64-bit RISC-V core fetches next. Each cycle it may accept one 32-bit instruction word together with that instruction's program counter and the two source register values. It sorts the instruction into one of four control kinds: sequential, conditional branch, jump-and-link, or register-indirect jump. It rebuilds the scattered branch and jump immediates and sign-extends them. It evaluates the branch condition. It registers four results: the next PC, the link value, a link-write flag and a redirect flag.

The result register is the block's only state. It has two named situations. When `in_valid` is high, the LOAD transition captures a fresh result and `out_valid` rises one cycle later. When `in_valid` is low, the HOLD transition keeps every result output unchanged and drops `out_valid`. Reset clears everything. Three next-PC sources exist: PC+4, PC plus a sign-extended immediate, and a register value plus an immediate. A greater-than test needs no comparator of its own, because it is issued as a less-than with swapped operands. Register file access, compressed instructions and exception handling belong to other blocks.

Top module: `npc_branch_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `next_pc`, `link_val`, `link_we` and `redirect` are all zero.
- R2: `out_valid` equals `in_valid` one clock later. When `in_valid` is low, `next_pc`, `link_val`, `link_we` and `redirect` keep their previous values.
- R3: An instruction whose opcode `instr[6:0]` is not 1100011, 1101111 or 1100111 gives `next_pc` = PC+4, with `redirect` = 0 and `link_we` = 0.
- R4: The branch offset is the 13-bit value with bit 12 = `instr[31]`, bit 11 = `instr[7]`, bits 10:5 = `instr[30:25]`, bits 4:1 = `instr[11:8]` and bit 0 = 0. It is sign-extended, so offsets from -4096 to +4094 are reachable.
- R5: For opcode 1100011, funct3 `instr[14:12]` = 000 takes the branch when `src_a` == `src_b`, and 001 takes it when they differ. A taken branch gives `next_pc` = PC+offset and `redirect` = 1. A branch that is not taken gives PC+4 and `redirect` = 0.
- R6: funct3 100 takes the branch when `src_a` < `src_b` as signed 64-bit values. funct3 101 takes it when `src_a` >= `src_b` as signed values.
- R7: funct3 110 and 111 make the same two tests as unsigned 64-bit values.
- R8: Under opcode 1100011, funct3 010 and 011 are never taken: `next_pc` = PC+4 and `redirect` = 0.
- R9: Opcode 1101111 gives `next_pc` = PC + J-offset and `redirect` = 1. The J-offset has bit 20 = `instr[31]`, bits 19:12 = `instr[19:12]`, bit 11 = `instr[20]`, bits 10:1 = `instr[30:21]` and bit 0 = 0, and it is sign-extended. `link_we` is 1 unless rd `instr[11:7]` is 0.
- R10: Opcode 1100111 gives `next_pc` = (`src_a` + sign-extended `instr[31:20]`) with bit 0 forced to 0, and `redirect` = 1. `link_we` follows the same rd rule as R9.
- R11: `link_val` is PC+4 for every accepted instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word and operands are present this cycle |
| instr | input | 32 | Instruction word |
| cur_pc | input | XLEN | PC of the instruction |
| src_a | input | XLEN | First source register value |
| src_b | input | XLEN | Second source register value |
| out_valid | output | 1 | Results below belong to the instruction accepted last cycle |
| next_pc | output | XLEN | Address to fetch next |
| link_val | output | XLEN | Return address (PC+4) |
| link_we | output | 1 | Link value is to be written (jump with nonzero rd) |
| redirect | output | 1 | Fetch leaves the sequential path |

## Verification
The embedded properties check on every cycle the one-cycle relation between the input and output valid flags, holding during idle cycles, the PC+4 result for non-control opcodes, the link value and rd rule for jumps, the even register-jump target, the never-taken reserved conditions and the taken equal branch. Only the bench's scenarios can show that the scattered offset bits land in the right places at the extreme offsets, and that signed and unsigned ordering differ for operands of opposite sign. The same applies to the arithmetic of every taken target, which the bench checks against a behavioural model over directed and random instruction words.

// File: rtl/npc_pkg.sv
`timescale 1ns/1ps
package npc_pkg;
    localparam int ILEN = 32;

    localparam logic [6:0] OP_BRANCH = 7'b1100011;
    localparam logic [6:0] OP_JAL    = 7'b1101111;
    localparam logic [6:0] OP_JALR   = 7'b1100111;

    localparam logic [2:0] F3_EQ  = 3'b000;
    localparam logic [2:0] F3_NE  = 3'b001;
    localparam logic [2:0] F3_LT  = 3'b100;
    localparam logic [2:0] F3_GE  = 3'b101;
    localparam logic [2:0] F3_LTU = 3'b110;
    localparam logic [2:0] F3_GEU = 3'b111;

    typedef enum logic [1:0] {
        K_SEQ,
        K_BRANCH,
        K_JAL,
        K_JALR
    } ctl_kind_e;
endpackage

// File: rtl/npc_imm_gen.sv
`timescale 1ns/1ps
module npc_imm_gen
    import npc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [ILEN-1:7]  iw_hi,
    output logic [XLEN-1:0]  b_imm,
    output logic [XLEN-1:0]  j_imm,
    output logic [XLEN-1:0]  i_imm
);
    localparam int BW = 13;
    localparam int JW = 21;
    localparam int IW = 12;

    // Branch offset: sign, bit 11 from the low field, then the two middle slices.
    assign b_imm = {{(XLEN-BW){iw_hi[31]}}, iw_hi[31], iw_hi[7],
                    iw_hi[30:25], iw_hi[11:8], 1'b0};

    // Jump offset: sign, upper byte, bit 11, low ten bits.
    assign j_imm = {{(XLEN-JW){iw_hi[31]}}, iw_hi[31], iw_hi[19:12],
                    iw_hi[20], iw_hi[30:21], 1'b0};

    // Register-jump offset is contiguous.
    assign i_imm = {{(XLEN-IW){iw_hi[31]}}, iw_hi[31:20]};
endmodule

// File: rtl/npc_branch_cond.sv
`timescale 1ns/1ps
module npc_branch_cond
    import npc_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter bit UNSIGNED_EN = 1'b1
) (
    input  logic [2:0]      funct3,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic            take
);
    logic eq;
    logic lt_s;
    logic lt_u;
    logic take_u;

    assign eq   = (opa == opb);
    assign lt_s = ($signed(opa) < $signed(opb));
    assign lt_u = (opa < opb);

    generate
        if (UNSIGNED_EN) begin : g_unsigned
            always_comb take_u = funct3[0] ? !lt_u : lt_u;
        end else begin : g_no_unsigned
            always_comb take_u = 1'b0;
        end
    endgenerate

    always_comb begin
        unique case (funct3)
            F3_EQ:          take = eq;
            F3_NE:          take = !eq;
            F3_LT:          take = lt_s;
            F3_GE:          take = !lt_s;
            F3_LTU, F3_GEU: take = take_u;
            default:        take = 1'b0;   // R8: reserved conditions fall through
        endcase
    end
endmodule

// File: rtl/npc_target_sel.sv
`timescale 1ns/1ps
module npc_target_sel
    import npc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  ctl_kind_e       kind,
    input  logic            take,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] rs1,
    input  logic [XLEN-1:0] b_imm,
    input  logic [XLEN-1:0] j_imm,
    input  logic [XLEN-1:0] i_imm,
    output logic [XLEN-1:0] target,
    output logic [XLEN-1:0] seq_pc,
    output logic            redirect
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0] rel_off;
    logic [XLEN-1:0] rel_tgt;
    logic [XLEN-1:0] reg_sum;
    logic [XLEN-1:0] reg_tgt;

    assign seq_pc  = pc + STEP;
    // One PC-relative adder shared by branches and jal.
    assign rel_off = (kind == K_JAL) ? j_imm : b_imm;
    assign rel_tgt = pc + rel_off;
    assign reg_sum = rs1 + i_imm;
    assign reg_tgt = {reg_sum[XLEN-1:1], 1'b0};

    always_comb begin
        unique case (kind)
            K_SEQ: begin
                target   = seq_pc;
                redirect = 1'b0;
            end
            K_BRANCH: begin
                target   = take ? rel_tgt : seq_pc;
                redirect = take;
            end
            K_JAL: begin
                target   = rel_tgt;
                redirect = 1'b1;
            end
            K_JALR: begin
                target   = reg_tgt;
                redirect = 1'b1;
            end
            default: begin
                target   = seq_pc;
                redirect = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/npc_branch_unit.sv
`timescale 1ns/1ps
module npc_branch_unit
    import npc_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter bit UNSIGNED_EN = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    output logic            out_valid,
    output logic [XLEN-1:0] next_pc,
    output logic [XLEN-1:0] link_val,
    output logic            link_we,
    output logic            redirect
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [6:0]      opcode;
    logic [4:0]      rd;
    logic [2:0]      funct3;
    ctl_kind_e       kind;
    logic [XLEN-1:0] b_imm;
    logic [XLEN-1:0] j_imm;
    logic [XLEN-1:0] i_imm;
    logic            take;
    logic [XLEN-1:0] target;
    logic [XLEN-1:0] seq_pc;
    logic            redir_d;
    logic            we_d;

    assign opcode = instr[6:0];
    assign rd     = instr[11:7];
    assign funct3 = instr[14:12];

    always_comb begin
        unique case (opcode)
            OP_BRANCH: kind = K_BRANCH;
            OP_JAL:    kind = K_JAL;
            OP_JALR:   kind = K_JALR;
            default:   kind = K_SEQ;
        endcase
    end

    npc_imm_gen #(.XLEN(XLEN)) u_imm (
        .iw_hi (instr[31:7]),
        .b_imm (b_imm),
        .j_imm (j_imm),
        .i_imm (i_imm)
    );

    npc_branch_cond #(.XLEN(XLEN), .UNSIGNED_EN(UNSIGNED_EN)) u_cond (
        .funct3 (funct3),
        .opa    (src_a),
        .opb    (src_b),
        .take   (take)
    );

    npc_target_sel #(.XLEN(XLEN)) u_sel (
        .kind     (kind),
        .take     (take),
        .pc       (cur_pc),
        .rs1      (src_a),
        .b_imm    (b_imm),
        .j_imm    (j_imm),
        .i_imm    (i_imm),
        .target   (target),
        .seq_pc   (seq_pc),
        .redirect (redir_d)
    );

    assign we_d = ((kind == K_JAL) || (kind == K_JALR)) && (rd != 5'd0);

    // Result register: LOAD on in_valid, HOLD otherwise.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            next_pc   <= '0;
            link_val  <= '0;
            link_we   <= 1'b0;
            redirect  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                next_pc  <= target;
                link_val <= seq_pc;
                link_we  <= we_d;
                redirect <= redir_d;
            end
        end
    end

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_valid)));

    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(next_pc) && $stable(link_val)
                       && $stable(link_we) && $stable(redirect)));

    a_r3_sequential_step: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode != OP_BRANCH && opcode != OP_JAL && opcode != OP_JALR)
        |=> (next_pc == $past(cur_pc) + STEP && !redirect && !link_we));

    a_r5_equal_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == OP_BRANCH && funct3 == F3_EQ && src_a == src_b)
        |=> redirect);

    a_r8_reserved_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == OP_BRANCH && funct3[2:1] == 2'b01)
        |=> (!redirect && next_pc == $past(cur_pc) + STEP));

    a_r9_no_link_to_x0: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (opcode == OP_JAL || opcode == OP_JALR) && rd == 5'd0)
        |=> (!link_we && redirect));

    a_r10_reg_target_even: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == OP_JALR) |=> (next_pc[0] == 1'b0));

    a_r11_link_value: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (link_val == $past(cur_pc) + STEP));
endmodule

// File: tb/test_npc_branch_unit.sv
`timescale 1ns/1ps
module test_npc_branch_unit;
    localparam int XLEN = 64;

    logic            clk;
    logic            rst_n;
    logic            in_valid;
    logic [31:0]     instr;
    logic [XLEN-1:0] cur_pc;
    logic [XLEN-1:0] src_a;
    logic [XLEN-1:0] src_b;
    logic            out_valid;
    logic [XLEN-1:0] next_pc;
    logic [XLEN-1:0] link_val;
    logic            link_we;
    logic            redirect;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // behavioural model state
    logic        m_valid;
    logic [63:0] m_next;
    logic [63:0] m_link;
    logic        m_we;
    logic        m_redir;

    npc_branch_unit #(.XLEN(XLEN)) i_npc_branch_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .cur_pc(cur_pc), .src_a(src_a), .src_b(src_b),
        .out_valid(out_valid), .next_pc(next_pc), .link_val(link_val),
        .link_we(link_we), .redirect(redirect)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic longint sext(longint v, int bits);
        longint half = longint'(1) << (bits - 1);
        return (v >= half) ? v - (half * 2) : v;
    endfunction

    // Reference: behavioural decode, written from the requirements.
    task automatic model_step(logic [31:0] iw, logic [63:0] pc, logic [63:0] a, logic [63:0] b);
        longint bo, jo, io;
        bit     tk;
        logic [63:0] seq;
        bo = (longint'(iw[31]) * 4096) + (longint'(iw[7]) * 2048)
           + (longint'(iw[30:25]) * 32) + (longint'(iw[11:8]) * 2);
        bo = sext(bo, 13);
        jo = (longint'(iw[31]) * 1048576) + (longint'(iw[19:12]) * 4096)
           + (longint'(iw[20]) * 2048) + (longint'(iw[30:21]) * 2);
        jo = sext(jo, 21);
        io = sext(longint'(iw[31:20]), 12);
        seq = pc + 64'd4;
        m_link = seq;
        m_we = 0;
        m_redir = 0;
        m_next = seq;
        if (iw[6:0] == 7'b1100011) begin
            case (iw[14:12])
                3'd0: tk = (a == b);
                3'd1: tk = (a != b);
                3'd4: tk = (longint'(a) < longint'(b));
                3'd5: tk = (longint'(a) >= longint'(b));
                3'd6: tk = (a < b);
                3'd7: tk = (a >= b);
                default: tk = 0;
            endcase
            if (tk) begin
                m_next = pc + 64'(bo);
                m_redir = 1;
            end
        end else if (iw[6:0] == 7'b1101111) begin
            m_next = pc + 64'(jo);
            m_redir = 1;
            m_we = (iw[11:7] != 0);
        end else if (iw[6:0] == 7'b1100111) begin
            m_next = (a + 64'(io)) & ~64'd1;
            m_redir = 1;
            m_we = (iw[11:7] != 0);
        end
    endtask

    // Apply one cycle of stimulus at a falling edge; compare at the next falling edge.
    task automatic apply(bit v, logic [31:0] iw, logic [63:0] pc, logic [63:0] a,
                         logic [63:0] b, string tag);
        in_valid = v;
        instr = iw;
        cur_pc = pc;
        src_a = a;
        src_b = b;
        m_valid = v;
        if (v) model_step(iw, pc, a, b);
        @(negedge clk);
        chk(tag, "out_valid", 64'(out_valid), 64'(m_valid));
        chk(tag, "next_pc", next_pc, m_next);
        chk(tag, "link_val", link_val, m_link);
        chk(tag, "link_we", 64'(link_we), 64'(m_we));
        chk(tag, "redirect", 64'(redirect), 64'(m_redir));
    endtask

    function automatic logic [31:0] enc_b(int off, logic [2:0] f3);
        logic [12:0] u = 13'(off);
        return {u[12], u[10:5], 5'd2, 5'd1, f3, u[4:1], u[11], 7'b1100011};
    endfunction

    function automatic logic [31:0] enc_j(int off, logic [4:0] rd);
        logic [20:0] u = 21'(off);
        return {u[20], u[10:1], u[11], u[19:12], rd, 7'b1101111};
    endfunction

    function automatic logic [31:0] enc_i(int off, logic [4:0] rd, logic [6:0] op);
        return {12'(off), 5'd1, 3'b000, rd, op};
    endfunction

    function automatic string tag_of(logic [31:0] iw);
        if (iw[6:0] == 7'b1100011) begin
            if (iw[14:13] == 2'b01) return "R8";
            if (iw[14:13] == 2'b00) return "R5";
            if (iw[14:13] == 2'b10) return "R6";
            return "R7";
        end
        if (iw[6:0] == 7'b1101111) return "R9";
        if (iw[6:0] == 7'b1100111) return "R10";
        return "R3";
    endfunction

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 0;
        in_valid = 0; instr = 0; cur_pc = 0; src_a = 0; src_b = 0;
        m_valid = 0; m_next = 0; m_link = 0; m_we = 0; m_redir = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "out_valid", 64'(out_valid), 64'd0);
        chk("R1", "next_pc", next_pc, 64'd0);
        chk("R1", "link_val", link_val, 64'd0);
        chk("R1", "link_we", 64'(link_we), 64'd0);
        chk("R1", "redirect", 64'(redirect), 64'd0);
        rst_n = 1;
        @(negedge clk);

        // R3: non-control opcode
        apply(1, enc_i(5, 5'd3, 7'b0010011), 64'h1000, 64'd7, 64'd9, "R3");
        chk("R3", "pc+4", next_pc, 64'h1004);
        // R4/R5: beq taken backward, not taken
        apply(1, enc_b(-8, 3'b000), 64'h1000, 64'd5, 64'd5, "R5");
        chk("R4", "beq -8", next_pc, 64'hFF8);
        apply(1, enc_b(-8, 3'b000), 64'h1000, 64'd5, 64'd6, "R5");
        chk("R5", "beq not taken", next_pc, 64'h1004);
        apply(1, enc_b(64, 3'b001), 64'h2000, 64'd5, 64'd6, "R5");
        chk("R5", "bne taken", next_pc, 64'h2040);
        // R4: extreme offsets
        apply(1, enc_b(4094, 3'b000), 64'h10000, 64'd1, 64'd1, "R4");
        chk("R4", "max offset", next_pc, 64'h10FFE);
        apply(1, enc_b(-4096, 3'b000), 64'h10000, 64'd1, 64'd1, "R4");
        chk("R4", "min offset", next_pc, 64'hF000);
        // R6 vs R7: opposite-sign operands
        apply(1, enc_b(16, 3'b100), 64'h3000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R6");
        chk("R6", "blt -1<1", 64'(redirect), 64'd1);
        apply(1, enc_b(16, 3'b110), 64'h3000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R7");
        chk("R7", "bltu max<1", 64'(redirect), 64'd0);
        apply(1, enc_b(16, 3'b101), 64'h3000, 64'hFFFF_FFFF_FFFF_FFFB, 64'hFFFF_FFFF_FFFF_FFFB, "R6");
        chk("R6", "bge equal", next_pc, 64'h3010);
        apply(1, enc_b(16, 3'b111), 64'h3000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R7");
        chk("R7", "bgeu max>=1", next_pc, 64'h3010);
        // R8: reserved condition codes
        apply(1, enc_b(16, 3'b010), 64'h3000, 64'd4, 64'd4, "R8");
        chk("R8", "f3=010", next_pc, 64'h3004);
        apply(1, enc_b(16, 3'b011), 64'h3000, 64'd4, 64'd9, "R8");
        chk("R8", "f3=011", 64'(redirect), 64'd0);
        // R9: jal with rd=0 and rd=1, extreme offsets
        apply(1, enc_j(-1048576, 5'd0), 64'h20_0000, 64'd0, 64'd0, "R9");
        chk("R9", "j min", next_pc, 64'h10_0000);
        chk("R9", "j no link", 64'(link_we), 64'd0);
        apply(1, enc_j(1048574, 5'd1), 64'h20_0000, 64'd0, 64'd0, "R9");
        chk("R9", "call max", next_pc, 64'h2F_FFFE);
        chk("R11", "call link", link_val, 64'h20_0004);
        // R10: jalr with odd sum and negative offset
        apply(1, enc_i(4, 5'd1, 7'b1100111), 64'h500, 64'h2003, 64'd0, "R10");
        chk("R10", "jalr clear bit0", next_pc, 64'h2006);
        apply(1, enc_i(-2048, 5'd5, 7'b1100111), 64'h500, 64'h1000, 64'd0, "R10");
        chk("R10", "jalr -2048", next_pc, 64'h800);
        // R2: idle cycles with changing inputs hold the outputs
        apply(0, enc_j(64, 5'd1), 64'h9000, 64'd1, 64'd2, "R2");
        chk("R2", "held next_pc", next_pc, 64'h800);
        apply(0, enc_b(8, 3'b000), 64'h9100, 64'd3, 64'd3, "R2");

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [31:0] iw;
            logic [63:0] a, b, pc;
            int sel;
            iw  = $urandom;
            sel = $urandom_range(0, 4);
            case (sel)
                0, 1: iw[6:0] = 7'b1100011;
                2: iw[6:0] = 7'b1101111;
                3: iw[6:0] = 7'b1100111;
                default: ;
            endcase
            a  = {$urandom, $urandom};
            b  = ($urandom_range(0, 3) == 0) ? a : {$urandom, $urandom};
            pc = {$urandom, $urandom} & ~64'd3;
            apply($urandom_range(0, 5) != 0, iw, pc, a, b, tag_of(iw));
        end

        finish_run();
    end
endmodule